// File: doc/BRIEF.md
# Word Compaction Bus Link

This block carries 32-bit words across a 16-bit link by compacting each word on its own. A compactor at the sending end keeps a small table of recently used high-order word parts (tags). When the tag of an incoming word sits in the table, the word crosses the link as a single beat holding the table index and the untouched low-order bits. When it does not, the word crosses as two raw beats and its tag is written into the table. An expander at the receiving end keeps a mirror of that table and rebuilds every word exactly.

The two tables stay identical without any extra traffic. Both ends write the same tag into the entry named by a round-robin pointer, and both do it on the handshake of the second raw beat. A sideband flag marks each beat as compact or raw. Both word-side ports use valid/ready. A word is taken when `in_valid` and `in_ready` are both high at a clock edge. The compactor lowers `in_ready` while the second half of a raw word is still pending. The rebuilt word stays on `out_data` with `out_valid` high until `out_ready` is high at an edge. While it waits, the expander refuses link beats. That back-pressure reaches the sender through the link handshake.

The link signals are brought out as outputs so the traffic on the link can be observed.

Top module: `wcl_link`

## Requirements
- R1: After reset, `out_valid` is low. `link_valid` is low while `in_valid` is low. Every table entry is invalid, so the first word after reset crosses as raw beats.
- R2: A word whose tag (bits 31:12) is not in the table crosses as two beats with `link_hit` low. The first beat carries word bits 31:16 and the second carries bits 15:0.
- R3: During the second beat of a raw word, `in_ready` is low.
- R4: A word whose tag is in the table crosses as one beat with `link_hit` high. The beat carries the entry index in bits 15:12 and word bits 11:0 in bits 11:0.
- R5: The n-th raw word since reset (counting from 0) stores its tag in entry n mod 16. The 17th distinct tag therefore replaces the tag of the first, and that first tag then misses again.
- R6: `out_data` delivers every accepted word unchanged, in the order the words were accepted.
- R7: With `out_ready` high, `out_valid` is high in the cycle after the final beat of a word is transferred. That is one cycle after a compact beat and one cycle after the second raw beat.
- R8: While `out_valid` is high and `out_ready` is low, `out_data` holds steady, `link_ready` is low, no beat moves and no word is lost.
- R9: While `in_valid` is low, no beat is sent and the table does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sender word valid |
| in_ready | output | 1 | Compactor accepts the word |
| in_data | input | 32 | Word to send |
| out_valid | output | 1 | Rebuilt word valid |
| out_ready | input | 1 | Receiver accepts the rebuilt word |
| out_data | output | 32 | Rebuilt word |
| link_valid | output | 1 | Beat present on the link |
| link_ready | output | 1 | Expander accepts the beat |
| link_hit | output | 1 | 1 = compact beat (index and low bits), 0 = raw half-word |
| link_data | output | 16 | Beat payload |

## Verification
The first word after reset shows that an empty table gives raw beats and puts the upper half first. Repeating a tag then separates a compact beat from a raw one. Sixteen distinct tags followed by hits on each of them tell a correct round-robin index apart from a stale or fixed one. A seventeenth tag shows that the oldest entry is evicted rather than some other entry. A stalled receiver with a second word queued behind it separates a proper hold from a dropped or overwritten word. An idle gap followed by a repeated word shows that the table is left alone when nothing is sent.

// File: rtl/wcl_pkg.sv
package wcl_pkg;
  // phase of a word on the link: upper beat (or the only beat) / lower beat
  typedef enum logic {PH_FIRST = 1'b0, PH_SECOND = 1'b1} phase_e;
endpackage

// File: rtl/wcl_table.sv
// Tag store with round-robin replacement; one instance at each link end.
module wcl_table #(
  parameter int TAG_W = 20,
  parameter int IDX_W = 4,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [TAG_W-1:0]               wr_tag,
  output logic [ENTRIES-1:0][TAG_W-1:0]  tags,
  output logic [ENTRIES-1:0]             vld
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else if (wr_en) ptr_q <= ptr_q + 1'b1;
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[e]  <= 1'b0;
        tags[e] <= '0;
      end else if (wr_en && ptr_q == IDX_W'(e)) begin
        vld[e]  <= 1'b1;
        tags[e] <= wr_tag;
      end
    end
  end
endmodule

// File: rtl/wcl_match.sv
// Parallel tag compare; lowest matching index wins.
module wcl_match #(
  parameter int TAG_W = 20,
  parameter int IDX_W = 4,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic [TAG_W-1:0]               key,
  input  logic [ENTRIES-1:0][TAG_W-1:0]  tags,
  input  logic [ENTRIES-1:0]             vld,
  output logic                           hit,
  output logic [IDX_W-1:0]               idx
);
  logic [ENTRIES-1:0] eq;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
    assign eq[e] = vld[e] && (tags[e] == key);
  end

  always_comb begin
    idx = '0;
    for (int e = ENTRIES - 1; e >= 0; e--) begin
      if (eq[e]) idx = IDX_W'(e);
    end
  end

  assign hit = |eq;
endmodule

// File: rtl/wcl_compactor.sv
module wcl_compactor
  import wcl_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LINK_W = 16,
  parameter int IDX_W  = 4,
  localparam int LOW_W   = LINK_W - IDX_W,
  localparam int TAG_W   = WORD_W - LOW_W,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              lk_valid,
  input  logic              lk_ready,
  output logic              lk_hit,
  output logic [LINK_W-1:0] lk_data
);
  phase_e                           phase_q;
  logic [WORD_W-1:0]                hold_q;
  logic [ENTRIES-1:0][TAG_W-1:0]    tags;
  logic [ENTRIES-1:0]               vld;
  logic                             hit;
  logic [IDX_W-1:0]                 idx;
  logic                             wr_en;

  wcl_table #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_tag(hold_q[WORD_W-1:LOW_W]), .tags(tags), .vld(vld)
  );

  wcl_match #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
    .key(in_data[WORD_W-1:LOW_W]), .tags(tags), .vld(vld),
    .hit(hit), .idx(idx)
  );

  always_comb begin
    wr_en = 1'b0;
    if (phase_q == PH_FIRST) begin
      lk_valid = in_valid;
      lk_hit   = hit;
      lk_data  = hit ? {idx, in_data[LOW_W-1:0]} : in_data[WORD_W-1:WORD_W-LINK_W];
      in_ready = lk_ready;
    end else begin
      lk_valid = 1'b1;
      lk_hit   = 1'b0;
      lk_data  = hold_q[LINK_W-1:0];
      in_ready = 1'b0;
      wr_en    = lk_ready;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_FIRST;
      hold_q  <= '0;
    end else if (phase_q == PH_FIRST) begin
      if (in_valid && lk_ready && !hit) begin
        hold_q  <= in_data;
        phase_q <= PH_SECOND;
      end
    end else if (lk_ready) begin
      phase_q <= PH_FIRST;
    end
  end
endmodule

// File: rtl/wcl_expander.sv
module wcl_expander
  import wcl_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LINK_W = 16,
  parameter int IDX_W  = 4,
  localparam int LOW_W   = LINK_W - IDX_W,
  localparam int TAG_W   = WORD_W - LOW_W,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic              lk_hit,
  input  logic [LINK_W-1:0] lk_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  phase_e                         phase_q;
  logic [LINK_W-1:0]              upper_q;
  logic [ENTRIES-1:0][TAG_W-1:0]  tags;
  logic [ENTRIES-1:0]             vld;
  logic [IDX_W-1:0]               rd_idx;
  logic [TAG_W-1:0]               rd_tag;
  logic                           fire;
  logic                           wr_en;

  assign lk_ready = !out_valid || out_ready;
  assign fire     = lk_valid && lk_ready;
  assign wr_en    = fire && (phase_q == PH_SECOND);
  assign rd_idx   = lk_data[LINK_W-1:LOW_W];
  assign rd_tag   = vld[rd_idx] ? tags[rd_idx] : '0;

  wcl_table #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
    .wr_tag({upper_q, lk_data[LINK_W-1:LOW_W]}), .tags(tags), .vld(vld)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q   <= PH_FIRST;
      upper_q   <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (fire) begin
        if (phase_q == PH_SECOND) begin
          out_data  <= {upper_q, lk_data};
          out_valid <= 1'b1;
          phase_q   <= PH_FIRST;
        end else if (lk_hit) begin
          out_data  <= {rd_tag, lk_data[LOW_W-1:0]};
          out_valid <= 1'b1;
        end else begin
          upper_q <= lk_data;
          phase_q <= PH_SECOND;
        end
      end
    end
  end
endmodule

// File: rtl/wcl_link.sv
module wcl_link #(
  parameter int WORD_W = 32,
  parameter int LINK_W = 16,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              link_valid,
  output logic              link_ready,
  output logic              link_hit,
  output logic [LINK_W-1:0] link_data
);
  wcl_compactor #(.WORD_W(WORD_W), .LINK_W(LINK_W), .IDX_W(IDX_W)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .lk_valid(link_valid), .lk_ready(link_ready),
    .lk_hit(link_hit), .lk_data(link_data)
  );

  wcl_expander #(.WORD_W(WORD_W), .LINK_W(LINK_W), .IDX_W(IDX_W)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .lk_valid(link_valid), .lk_ready(link_ready),
    .lk_hit(link_hit), .lk_data(link_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );
endmodule

// File: rtl/wcl_link_chk.sv
module wcl_link_chk #(
  parameter int WORD_W = 32,
  parameter int LINK_W = 16,
  parameter int IDX_W  = 4,
  localparam int LOW_W = LINK_W - IDX_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              link_valid,
  input logic              link_ready,
  input logic              link_hit,
  input logic [LINK_W-1:0] link_data
);
  a_r2_upper_first: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !link_hit) |-> link_data == in_data[WORD_W-1:WORD_W-LINK_W]);

  a_r3_second_beat_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !link_hit) |=> (!in_ready && link_valid && !link_hit));

  a_r4_low_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (link_valid && link_hit) |-> link_data[LOW_W-1:0] == in_data[LOW_W-1:0]);

  a_r7_hit_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (link_valid && link_ready && link_hit) |=>
      (out_valid && out_data[LOW_W-1:0] == $past(link_data[LOW_W-1:0])));

  a_r8_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r8_stall_link: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !link_ready);

  a_r9_quiet_link: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && in_ready) |-> !link_valid);
endmodule

bind wcl_link wcl_link_chk #(.WORD_W(WORD_W), .LINK_W(LINK_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/wcl_link_tb.sv
module wcl_link_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;
  logic        link_valid, link_ready, link_hit;
  logic [15:0] link_data;

  int n_chk = 0, n_fail = 0;
  int cyc = 0, nb = 0, nr = 0;
  logic        b_hit [512];
  logic [15:0] b_dat [512];
  int          b_cyc [512];
  logic [31:0] rx    [512];
  int          r_cyc [512];

  // bench model of the tag table
  logic [19:0] m_tag [16];
  logic [15:0] m_val = '0;
  int          m_ptr = 0;

  always #5 clk = ~clk;

  wcl_link u_dut (.*);

  always @(posedge clk) begin
    if (rst_n) begin
      cyc++;
      if (link_valid && link_ready && nb < 512) begin
        b_hit[nb] = link_hit; b_dat[nb] = link_data; b_cyc[nb] = cyc; nb++;
      end
      if (out_valid && out_ready && nr < 512) begin
        rx[nr] = out_data; r_cyc[nr] = cyc; nr++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int m_find(input logic [19:0] t);
    for (int e = 0; e < 16; e++) if (m_val[e] && m_tag[e] == t) return e;
    return -1;
  endfunction

  task automatic send(input logic [31:0] w, output bit busy);
    @(negedge clk); in_valid = 1'b1; in_data = w;
    while (!in_ready) @(negedge clk);
    @(negedge clk); busy = !in_ready; in_valid = 1'b0;
  endtask

  task automatic xfer(input logic [31:0] w);
    int nb0 = nb, nr0 = nr, ix;
    bit busy;
    ix = m_find(w[31:12]);
    send(w, busy);
    for (int k = 0; k < 20 && nr == nr0; k++) @(negedge clk);
    if (ix >= 0) begin
      chk(nb - nb0 == 1, "R4 one beat", nb - nb0, 1);
      chk(b_hit[nb0] == 1'b1, "R4 hit flag", b_hit[nb0], 1);
      chk(b_dat[nb0] == {ix[3:0], w[11:0]}, "R4/R5 beat", b_dat[nb0], {ix[3:0], w[11:0]});
    end else begin
      chk(nb - nb0 == 2, "R2 two beats", nb - nb0, 2);
      chk(!b_hit[nb0] && !b_hit[nb0+1], "R2 raw flags", {b_hit[nb0], b_hit[nb0+1]}, 0);
      chk(b_dat[nb0] == w[31:16], "R2 upper first", b_dat[nb0], w[31:16]);
      chk(b_dat[nb0+1] == w[15:0], "R2 lower second", b_dat[nb0+1], w[15:0]);
      chk(busy, "R3 in_ready low", !busy, 0);
      m_tag[m_ptr] = w[31:12]; m_val[m_ptr] = 1'b1; m_ptr = (m_ptr + 1) % 16;
    end
    chk(nr == nr0 + 1 && rx[nr0] == w, "R6 word out", rx[nr0], w);
    chk(r_cyc[nr0] == b_cyc[nb-1] + 1, "R7 latency", r_cyc[nr0] - b_cyc[nb-1], 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!out_valid, "R1 out_valid", out_valid, 0);
    chk(!link_valid, "R1 link_valid", link_valid, 0);
    xfer(32'h1234_5678);   // R1: empty table -> raw
  endtask

  task automatic t_hit;
    xfer(32'h1234_5ABC);
    xfer(32'h1234_5000);
  endtask

  task automatic t_fill_evict;   // R5
    for (int i = 1; i < 16; i++) xfer({20'hA0000 + 20'(i), 12'(i * 7)});
    for (int i = 1; i < 16; i++) xfer({20'hA0000 + 20'(i), 12'hFFF - 12'(i)});
    xfer(32'h1234_5111);
    xfer(32'hBEEF_0123);       // 17th tag: evicts entry 0
    chk(m_find(20'h12345) < 0, "R5 model evict", 0, 0);
    xfer(32'h1234_5FFF);       // first tag misses again
    xfer(32'hBEEF_0777);
  endtask

  task automatic t_backpressure;  // R8
    int nr0, nb0;
    bit busy;
    nr0 = nr;
    out_ready = 1'b0;
    send(32'hA0003_123, busy);
    @(negedge clk);
    chk(out_valid && out_data == 32'hA0003_123, "R8 word held", out_data, 32'hA0003_123);
    nb0 = nb;
    fork
      send(32'hA0004_456, busy);
    join_none
    repeat (4) @(negedge clk);
    chk(out_valid && out_data == 32'hA0003_123, "R8 stable", out_data, 32'hA0003_123);
    chk(!link_ready && link_valid, "R8 link stalled", {link_valid, link_ready}, 2'b10);
    chk(nb == nb0, "R8 no beat", nb - nb0, 0);
    out_ready = 1'b1;
    wait fork;
    for (int k = 0; k < 20 && nr < nr0 + 2; k++) @(negedge clk);
    chk(nr == nr0 + 2, "R8 count", nr - nr0, 2);
    chk(rx[nr0] == 32'hA0003_123, "R6 order 0", rx[nr0], 32'hA0003_123);
    chk(rx[nr0+1] == 32'hA0004_456, "R6 order 1", rx[nr0+1], 32'hA0004_456);
  endtask

  task automatic t_idle;   // R9
    int nb0 = nb;
    repeat (10) @(negedge clk);
    chk(nb == nb0, "R9 idle beats", nb - nb0, 0);
    chk(!link_valid, "R9 link_valid", link_valid, 0);
    xfer(32'hBEEF_0AAA);     // table unchanged: still a hit at same index
    xfer(32'hA0009_001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_hit;
    t_fill_evict;
    t_backpressure;
    t_idle;
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule